// File: doc/BRIEF.md
# Tensor Tile Copy Engine

This block moves one rectangular tile of a tensor with one to five dimensions between a large global memory and a local scratchpad. A requester hands over a single descriptor: the tensor's base address, its rank, the size and element stride of each dimension, the tile extent in each dimension and the tile's starting coordinate. The requester supplies no per-element addresses. The engine walks the tile one element at a time, with dimension 0 varying fastest. When an index reaches its extent it returns to zero and carries into the next dimension. For each element the engine computes the global address and decides whether the element lies inside the tensor. The engine runs in either direction. A load copies global memory into the scratchpad and writes zero for any element that falls past the tensor's edge. A store copies the scratchpad into global memory and leaves out such elements.

The tile is packed densely in the scratchpad from a base address. When the transfer ends, the engine pulses a completion output that carries the number of bytes written to the destination. This lets the completion feed a byte-counting barrier directly. A request that cannot be carried out is turned away before any memory traffic. This covers a tile larger than the scratchpad, a zero extent, or a rank outside one to five. Only one request is handled at a time. A new request waits on `req_ready` until the current transfer has completed.

Top module: `tensor_tile_mover`

## Requirements
- R1: The request port is valid/ready. `req_ready` is high only when the engine is idle, and it falls in the cycle after a request is accepted. No memory request is issued while the engine is idle.
- R2: `req_rank` selects how many dimensions are active, from 1 to 5. For dimensions at or above the rank, the size, stride, extent and origin fields are ignored. A rank of 0 or above 5 is rejected.
- R3: Field d of each packed descriptor vector occupies bits [d*W +: W], and dimension 0 is innermost. Take an element at tile index i. Its global element address is `req_gbase` + Σ (origin_d + i_d) × stride_d, modulo 2^AW. Its scratchpad element address is `req_sbase` + its linear position in the tile, with dimension 0 fastest, modulo 2^SAW.
- R4: Load (`req_store` = 0) copies global memory to the scratchpad. An element with any coordinate origin_d + i_d ≥ size_d is not read from global memory, and the engine writes 0 to its scratchpad slot.
- R5: Store (`req_store` = 1) copies the scratchpad to global memory. An element that lies outside the tensor is neither read from the scratchpad nor written to global memory, so its global word keeps its old value.
- R6: The engine rejects a request when the product of the active tile extents exceeds SP_ELEMS, or when any active extent is 0. A rejected request completes with `done_err` = 1 and `done_bytes` = 0, and it issues no memory request. A tile of exactly SP_ELEMS elements is accepted.
- R7: Completion is a one-cycle pulse on `done_valid`. `done_bytes` equals the number of elements written to the destination, multiplied by EW/8. For a load, that count is every tile element, including the zero-filled ones. For a store, it is only the in-bounds elements.
- R8: Each memory request port is valid/ready. While a request is stalled, its valid, address, write flag and write data stay stable. At most one read is outstanding, and its data is taken in the cycle `*_rsp_valid` is high. The two memory ports never request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Descriptor offered |
| req_ready | output | 1 | Engine idle, descriptor accepted on this cycle if valid |
| req_store | input | 1 | 0 = load (global to scratchpad), 1 = store |
| req_rank | input | 3 | Number of active dimensions |
| req_gbase | input | AW | Tensor base element address in global memory |
| req_sbase | input | SAW | Tile base element address in the scratchpad |
| req_dims | input | 5×DW | Tensor size per dimension |
| req_strides | input | 5×AW | Element stride per dimension |
| req_box | input | 5×DW | Tile extent per dimension |
| req_origin | input | 5×DW | Tile start coordinate per dimension |
| gm_req_valid | output | 1 | Global memory request |
| gm_req_ready | input | 1 | Global memory accepts the request |
| gm_req_we | output | 1 | 1 = write, 0 = read |
| gm_req_addr | output | AW | Global element address |
| gm_req_wdata | output | EW | Global write data |
| gm_rsp_valid | input | 1 | Global read data valid |
| gm_rsp_rdata | input | EW | Global read data |
| sp_req_valid | output | 1 | Scratchpad request |
| sp_req_ready | input | 1 | Scratchpad accepts the request |
| sp_req_we | output | 1 | 1 = write, 0 = read |
| sp_req_addr | output | SAW | Scratchpad element address |
| sp_req_wdata | output | EW | Scratchpad write data |
| sp_rsp_valid | input | 1 | Scratchpad read data valid |
| sp_rsp_rdata | input | EW | Scratchpad read data |
| done_valid | output | 1 | Transfer complete (one cycle) |
| done_err | output | 1 | Request was rejected |
| done_bytes | output | BW | Bytes written to the destination |

## Verification
The checks assume that the memories return exactly one response for each accepted read. They also assume that no response arrives unrequested. The bench's memory models meet this by answering each read handshake one cycle later and never otherwise. The models still stall ready in irregular patterns on both ports, which keeps the hold-while-stalled properties busy. The checks also assume that descriptor fields stay stable only while offered. The bench therefore changes the fields only while `req_valid` is low, between requests.

// File: rtl/tile_copy_pkg.sv
package tile_copy_pkg;
  localparam int NDIM = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_WAIT,
    ST_PUT,
    ST_DONE
  } tc_state_e;
endpackage

// File: rtl/tc_odometer.sv
module tc_odometer #(
  parameter int ND = 5,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 step,
  input  logic [ND-1:0][DW-1:0] box,
  output logic [ND-1:0][DW-1:0] idx,
  output logic                 last
);
  logic [ND:0]   carry;
  logic [ND-1:0] wrap;

  assign carry[0] = step;

  for (genvar d = 0; d < ND; d++) begin : g_dim
    assign wrap[d]      = (idx[d] == DW'(box[d] - 1'b1));
    assign carry[d + 1] = carry[d] & wrap[d];

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        idx[d] <= '0;
      end else if (carry[d]) begin
        idx[d] <= wrap[d] ? '0 : idx[d] + 1'b1;
      end
    end
  end

  assign last = &wrap;
endmodule

// File: rtl/tc_addr_gen.sv
module tc_addr_gen #(
  parameter int ND = 5,
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic [AW-1:0]         gbase,
  input  logic [ND-1:0][DW-1:0] origin,
  input  logic [ND-1:0][DW-1:0] dims,
  input  logic [ND-1:0][AW-1:0] stride,
  input  logic [ND-1:0][DW-1:0] idx,
  output logic [AW-1:0]         gaddr,
  output logic                  inbounds
);
  localparam int CW = DW + 1;

  logic [ND-1:0]         dim_ok;
  logic [ND-1:0][AW-1:0] term;

  for (genvar d = 0; d < ND; d++) begin : g_term
    logic [CW-1:0] coord;
    assign coord     = {1'b0, origin[d]} + {1'b0, idx[d]};
    assign dim_ok[d] = coord < {1'b0, dims[d]};
    assign term[d]   = AW'(coord) * stride[d];
  end

  always_comb begin
    gaddr = gbase;
    for (int d = 0; d < ND; d++) begin
      gaddr = gaddr + term[d];
    end
  end

  assign inbounds = &dim_ok;
endmodule

// File: rtl/tc_size_check.sv
module tc_size_check #(
  parameter int ND       = 5,
  parameter int DW       = 8,
  parameter int SP_ELEMS = 256
) (
  input  logic [2:0]            rank,
  input  logic [ND-1:0][DW-1:0] box,
  output logic                  reject
);
  localparam int PW = ND * DW;

  logic [PW-1:0] prod;
  logic          any_zero;

  always_comb begin
    prod     = PW'(1);
    any_zero = 1'b0;
    for (int d = 0; d < ND; d++) begin
      prod = prod * PW'(box[d]);
      if (box[d] == '0) any_zero = 1'b1;
    end
  end

  assign reject = (rank == 3'd0) || (32'(rank) > ND) || any_zero ||
                  (prod > PW'(SP_ELEMS));
endmodule

// File: rtl/tensor_tile_mover.sv
module tensor_tile_mover
  import tile_copy_pkg::*;
#(
  parameter int AW       = 16,
  parameter int SAW      = 8,
  parameter int DW       = 8,
  parameter int EW       = 32,
  parameter int SP_ELEMS = 256,
  localparam int EB      = EW / 8,
  localparam int BW      = $clog2(SP_ELEMS * EB + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_store,
  input  logic [2:0]           req_rank,
  input  logic [AW-1:0]        req_gbase,
  input  logic [SAW-1:0]       req_sbase,
  input  logic [NDIM*DW-1:0]   req_dims,
  input  logic [NDIM*AW-1:0]   req_strides,
  input  logic [NDIM*DW-1:0]   req_box,
  input  logic [NDIM*DW-1:0]   req_origin,
  output logic                 gm_req_valid,
  input  logic                 gm_req_ready,
  output logic                 gm_req_we,
  output logic [AW-1:0]        gm_req_addr,
  output logic [EW-1:0]        gm_req_wdata,
  input  logic                 gm_rsp_valid,
  input  logic [EW-1:0]        gm_rsp_rdata,
  output logic                 sp_req_valid,
  input  logic                 sp_req_ready,
  output logic                 sp_req_we,
  output logic [SAW-1:0]       sp_req_addr,
  output logic [EW-1:0]        sp_req_wdata,
  input  logic                 sp_rsp_valid,
  input  logic [EW-1:0]        sp_rsp_rdata,
  output logic                 done_valid,
  output logic                 done_err,
  output logic [BW-1:0]        done_bytes
);
  tc_state_e state_q;

  logic                      store_q;
  logic [2:0]                rank_q;
  logic [AW-1:0]             gbase_q;
  logic [SAW-1:0]            sbase_q;
  logic [NDIM-1:0][DW-1:0]   dims_q, box_q, org_q, idx;
  logic [NDIM-1:0][AW-1:0]   str_q;
  logic [SAW-1:0]            lin_q;
  logic [EW-1:0]             data_q;
  logic [BW-1:0]             bytes_q;
  logic                      err_q;

  logic          accept, reject, last, inb, step;
  logic          src_fire, dst_fire, rsp_valid;
  logic [EW-1:0] rsp_data;
  logic [AW-1:0] gaddr;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // Latch the descriptor; dimensions above the rank become unit-sized.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= 1'b0;
      rank_q  <= '0;
      gbase_q <= '0;
      sbase_q <= '0;
      dims_q  <= '0;
      box_q   <= '0;
      org_q   <= '0;
      str_q   <= '0;
    end else if (accept) begin
      store_q <= req_store;
      rank_q  <= req_rank;
      gbase_q <= req_gbase;
      sbase_q <= req_sbase;
      for (int d = 0; d < NDIM; d++) begin
        if (d < 32'(req_rank)) begin
          dims_q[d] <= req_dims[d*DW +: DW];
          box_q[d]  <= req_box[d*DW +: DW];
          org_q[d]  <= req_origin[d*DW +: DW];
          str_q[d]  <= req_strides[d*AW +: AW];
        end else begin
          dims_q[d] <= DW'(1);
          box_q[d]  <= DW'(1);
          org_q[d]  <= '0;
          str_q[d]  <= '0;
        end
      end
    end
  end

  tc_size_check #(.ND(NDIM), .DW(DW), .SP_ELEMS(SP_ELEMS)) u_size (
    .rank   (rank_q),
    .box    (box_q),
    .reject (reject)
  );

  tc_odometer #(.ND(NDIM), .DW(DW)) u_odo (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (accept),
    .step  (step),
    .box   (box_q),
    .idx   (idx),
    .last  (last)
  );

  tc_addr_gen #(.ND(NDIM), .DW(DW), .AW(AW)) u_addr (
    .gbase    (gbase_q),
    .origin   (org_q),
    .dims     (dims_q),
    .stride   (str_q),
    .idx      (idx),
    .gaddr    (gaddr),
    .inbounds (inb)
  );

  // Port drive: fetch from the source side, put to the destination side.
  always_comb begin
    gm_req_valid = ((state_q == ST_FETCH) && !store_q && inb) ||
                   ((state_q == ST_PUT) && store_q);
    sp_req_valid = ((state_q == ST_FETCH) && store_q && inb) ||
                   ((state_q == ST_PUT) && !store_q);
    gm_req_we    = store_q;
    sp_req_we    = !store_q;
    gm_req_addr  = gaddr;
    sp_req_addr  = sbase_q + lin_q;
    gm_req_wdata = data_q;
    sp_req_wdata = data_q;
    src_fire  = (state_q == ST_FETCH) && inb &&
                (store_q ? sp_req_ready : gm_req_ready);
    dst_fire  = (state_q == ST_PUT) && (store_q ? gm_req_ready : sp_req_ready);
    rsp_valid = store_q ? sp_rsp_valid : gm_rsp_valid;
    rsp_data  = store_q ? sp_rsp_rdata : gm_rsp_rdata;
    step      = dst_fire || ((state_q == ST_FETCH) && store_q && !inb);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lin_q   <= '0;
      data_q  <= '0;
      bytes_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (step) lin_q <= lin_q + 1'b1;
      if (dst_fire) bytes_q <= bytes_q + BW'(EB);
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            lin_q   <= '0;
            bytes_q <= '0;
            err_q   <= 1'b0;
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (reject) begin
            err_q   <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (!inb) begin
            if (store_q) begin
              state_q <= last ? ST_DONE : ST_FETCH;
            end else begin
              data_q  <= '0;
              state_q <= ST_PUT;
            end
          end else if (src_fire) begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            data_q  <= rsp_data;
            state_q <= ST_PUT;
          end
        end
        ST_PUT: begin
          if (dst_fire) state_q <= last ? ST_DONE : ST_FETCH;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_valid = (state_q == ST_DONE);
  assign done_err   = err_q;
  assign done_bytes = bytes_q;
endmodule

// File: rtl/tensor_tile_mover_chk.sv
module tensor_tile_mover_chk #(
  parameter int AW  = 16,
  parameter int SAW = 8,
  parameter int EW  = 32,
  parameter int BW  = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           gm_req_valid,
  input logic           gm_req_ready,
  input logic           gm_req_we,
  input logic [AW-1:0]  gm_req_addr,
  input logic [EW-1:0]  gm_req_wdata,
  input logic           sp_req_valid,
  input logic           sp_req_ready,
  input logic           sp_req_we,
  input logic [SAW-1:0] sp_req_addr,
  input logic [EW-1:0]  sp_req_wdata,
  input logic           done_valid,
  input logic           done_err,
  input logic [BW-1:0]  done_bytes
);
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !gm_req_valid && !sp_req_valid); // R1

  AST_GM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    gm_req_valid && !gm_req_ready |=> gm_req_valid && $stable(gm_req_addr) &&
      $stable(gm_req_we) && $stable(gm_req_wdata)); // R8

  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sp_req_valid && !sp_req_ready |=> sp_req_valid && $stable(sp_req_addr) &&
      $stable(sp_req_we) && $stable(sp_req_wdata)); // R8

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(gm_req_valid && sp_req_valid)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R7

  AST_REJECT_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_err |-> done_bytes == '0); // R6
endmodule

bind tensor_tile_mover tensor_tile_mover_chk #(
  .AW(AW), .SAW(SAW), .EW(EW), .BW(BW)
) u_chk (.*);

// File: tb/tensor_tile_mover_tb.sv
module tensor_tile_mover_tb;
  localparam int AW = 16, SAW = 8, DW = 8, EW = 32, SPE = 256, BW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic req_valid = 1'b0, req_ready, req_store = 1'b0;
  logic [2:0] req_rank = '0;
  logic [AW-1:0] req_gbase = '0;
  logic [SAW-1:0] req_sbase = '0;
  logic [5*DW-1:0] req_dims = '0, req_box = '0, req_origin = '0;
  logic [5*AW-1:0] req_strides = '0;
  logic gm_req_valid, gm_req_ready = 1'b0, gm_req_we, gm_rsp_valid = 1'b0;
  logic [AW-1:0] gm_req_addr;
  logic [EW-1:0] gm_req_wdata, gm_rsp_rdata = '0;
  logic sp_req_valid, sp_req_ready = 1'b0, sp_req_we, sp_rsp_valid = 1'b0;
  logic [SAW-1:0] sp_req_addr;
  logic [EW-1:0] sp_req_wdata, sp_rsp_rdata = '0;
  logic done_valid, done_err;
  logic [BW-1:0] done_bytes;

  tensor_tile_mover u_dut (.*);

  logic [EW-1:0] gmem [0:4095];
  logic [EW-1:0] smem [0:255];
  int cyc = 0, n_gr = 0, n_gw = 0, n_sr = 0, n_sw = 0;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    gm_req_ready <= (cyc % 3) != 2;
    sp_req_ready <= (cyc % 4) != 1;
    gm_rsp_valid <= 1'b0;
    sp_rsp_valid <= 1'b0;
    if (gm_req_valid && gm_req_ready) begin
      if (gm_req_we) begin
        gmem[gm_req_addr[11:0]] <= gm_req_wdata;
        n_gw <= n_gw + 1;
      end else begin
        gm_rsp_valid <= 1'b1;
        gm_rsp_rdata <= gmem[gm_req_addr[11:0]];
        n_gr <= n_gr + 1;
      end
    end
    if (sp_req_valid && sp_req_ready) begin
      if (sp_req_we) begin
        smem[sp_req_addr] <= sp_req_wdata;
        n_sw <= n_sw + 1;
      end else begin
        sp_rsp_valid <= 1'b1;
        sp_rsp_rdata <= smem[sp_req_addr];
        n_sr <= n_sr + 1;
      end
    end
  end

  function automatic logic [EW-1:0] gpat(int a); return 32'hA500_0000 | a; endfunction
  function automatic logic [EW-1:0] spat(int a); return 32'h5A00_0000 | a; endfunction
  function automatic logic [EW-1:0] lpat(int a); return 32'hDEAD_0000 | a; endfunction

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  int t_dim[5], t_str[5], t_box[5], t_org[5];

  task automatic set_dim(int d, int dm, int st, int bx, int og);
    t_dim[d] = dm; t_str[d] = st; t_box[d] = bx; t_org[d] = og;
  endtask

  task automatic clear_dims();
    for (int d = 0; d < 5; d++) set_dim(d, 0, 0, 0, 0);
  endtask

  // Issue one request and compare the whole memory image, bytes and traffic.
  task automatic run(bit st, int rank, int gb, int sb, string rq);
    int ed[5], es[5], ebx[5], eo[5];
    logic [EW-1:0] gexp [0:4095];
    logic [EW-1:0] sexp [0:255];
    int elems = 1, inb_cnt = 0, lin = 0, bad = 0, first = -1;
    bit rej, zero = 1'b0;
    int gr0, gw0, sr0, sw0;
    longint exp_bytes;
    for (int i = 0; i < 4096; i++) gmem[i] <= gpat(i);
    for (int i = 0; i < 256; i++) smem[i] <= st ? spat(i) : lpat(i);
    @(negedge clk);
    for (int d = 0; d < 5; d++) begin
      bit act = d < rank;
      ed[d] = act ? t_dim[d] : 1; es[d] = act ? t_str[d] : 0;
      ebx[d] = act ? t_box[d] : 1; eo[d] = act ? t_org[d] : 0;
      if (ebx[d] == 0) zero = 1'b1;
      elems = elems * ebx[d];
      req_dims[d*DW +: DW] = DW'(t_dim[d]);
      req_strides[d*AW +: AW] = AW'(t_str[d]);
      req_box[d*DW +: DW] = DW'(t_box[d]);
      req_origin[d*DW +: DW] = DW'(t_org[d]);
    end
    rej = (rank < 1) || (rank > 5) || zero || (elems > SPE);
    for (int i = 0; i < 4096; i++) gexp[i] = gpat(i);
    for (int i = 0; i < 256; i++) sexp[i] = st ? spat(i) : lpat(i);
    if (!rej) begin
      for (int i4 = 0; i4 < ebx[4]; i4++)
      for (int i3 = 0; i3 < ebx[3]; i3++)
      for (int i2 = 0; i2 < ebx[2]; i2++)
      for (int i1 = 0; i1 < ebx[1]; i1++)
      for (int i0 = 0; i0 < ebx[0]; i0++) begin
        int c[5];
        int ga = gb;
        bit ok = 1'b1;
        int sa = (sb + lin) % 256;
        c[0] = eo[0] + i0; c[1] = eo[1] + i1; c[2] = eo[2] + i2;
        c[3] = eo[3] + i3; c[4] = eo[4] + i4;
        for (int d = 0; d < 5; d++) begin
          if (c[d] >= ed[d]) ok = 1'b0;
          ga = ga + c[d] * es[d];
        end
        ga = ga % 65536;
        if (ok) inb_cnt++;
        if (st) begin
          if (ok) gexp[ga % 4096] = spat(sa);
        end else begin
          sexp[sa] = ok ? gpat(ga % 4096) : '0;
        end
        lin++;
      end
    end
    exp_bytes = rej ? 0 : (st ? inb_cnt * 4 : elems * 4);
    gr0 = n_gr; gw0 = n_gw; sr0 = n_sr; sw0 = n_sw;
    req_store = st; req_rank = 3'(rank);
    req_gbase = AW'(gb); req_sbase = SAW'(sb);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready low while busy", req_ready, 0);
    while (!done_valid) @(negedge clk);
    chk(done_err == rej, rej ? "R6" : "R2", "done_err", done_err, rej);
    chk(done_bytes == BW'(exp_bytes), "R7", "done_bytes", done_bytes, exp_bytes);
    @(negedge clk);
    chk(done_valid == 1'b0, "R7", "done pulse single", done_valid, 0);
    @(negedge clk);
    if (st) begin
      for (int i = 0; i < 4096; i++) if (gmem[i] !== gexp[i]) begin
        bad++; if (first < 0) first = i;
      end
      if (first < 0) first = 0;
      chk(bad == 0, rq, "global image (R5)", gmem[first], gexp[first]);
      chk(n_gw - gw0 == inb_cnt && n_sr - sr0 == inb_cnt && n_sw == sw0 && n_gr == gr0,
          "R8", "store traffic", n_gw - gw0, inb_cnt);
    end else begin
      for (int i = 0; i < 256; i++) if (smem[i] !== sexp[i]) begin
        bad++; if (first < 0) first = i;
      end
      if (first < 0) first = 0;
      chk(bad == 0, rq, "scratch image (R4)", smem[first], sexp[first]);
      chk(n_gr - gr0 == inb_cnt && n_sw - sw0 == (rej ? 0 : elems) && n_gw == gw0 && n_sr == sr0,
          "R8", "load traffic", n_gr - gr0, inb_cnt);
    end
    if (rej) chk(n_gr == gr0 && n_gw == gw0 && n_sr == sr0 && n_sw == sw0,
                 "R6", "no traffic on reject", n_gr - gr0 + n_gw - gw0, 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && done_valid == 1'b0, "R1", "reset idle", req_ready, 1);
    chk(!gm_req_valid && !sp_req_valid, "R1", "reset quiet", gm_req_valid, 0);

    // R3 R4: 2-D loads over every origin, clipping at both edges
    clear_dims();
    for (int o1 = 0; o1 < 5; o1++)
      for (int o0 = 0; o0 < 7; o0++) begin
        set_dim(0, 5, 1, 3, o0); set_dim(1, 4, 5, 2, o1);
        run(1'b0, 2, 100, 7, "R4");
      end
    // R3 R5: 2-D stores over every origin
    for (int o1 = 0; o1 < 5; o1++)
      for (int o0 = 0; o0 < 7; o0++) begin
        set_dim(0, 5, 1, 3, o0); set_dim(1, 4, 5, 2, o1);
        run(1'b1, 2, 300, 250, "R5");
      end
    // R2: rank 1 with zero fields above the rank (would reject if used)
    clear_dims(); set_dim(0, 10, 1, 4, 8);
    run(1'b0, 1, 40, 0, "R2");
    // R3: rank 3 with sparse strides
    clear_dims(); set_dim(0, 3, 1, 2, 2); set_dim(1, 3, 4, 2, 1); set_dim(2, 2, 16, 2, 1);
    run(1'b0, 3, 500, 20, "R3");
    run(1'b1, 3, 500, 20, "R3");
    // R3: rank 5 store and load, with clipping in two dimensions
    for (int d = 0; d < 5; d++) set_dim(d, 2, 1 << d, 2, 0);
    run(1'b1, 5, 1000, 3, "R3");
    t_org[0] = 1; t_org[4] = 1;
    run(1'b0, 5, 1000, 3, "R3");
    // R6: tile just over capacity, exactly at capacity, zero extent
    clear_dims(); set_dim(0, 17, 1, 17, 0); set_dim(1, 16, 17, 16, 0);
    run(1'b0, 2, 0, 0, "R6");
    set_dim(0, 16, 1, 16, 0); set_dim(1, 16, 16, 16, 0);
    run(1'b0, 2, 2048, 0, "R6");
    set_dim(1, 16, 16, 0, 0);
    run(1'b1, 2, 0, 0, "R6");
    // R2: rank out of range
    set_dim(1, 16, 16, 2, 0);
    run(1'b0, 0, 0, 0, "R2");
    run(1'b0, 6, 0, 0, "R2");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule